// File: doc/BRIEF.md
# Serial Slave Register Port with Per-Transfer Clock Polarity Detection

This block is a serial peripheral slave for a small sensor-style register file. It runs entirely in the system clock domain. It passes the select, serial clock and serial data pins through a synchronizer and then detects clock edges on the synchronized copies. Each time the active-high select rises, the block latches the level the serial clock is resting at. That level chooses which edge samples incoming data and which edge moves outgoing data. When the clock rests high, data is sampled on rising edges and driven on falling edges. When it rests low, the roles swap. The first edge that leaves the idle level is therefore always a driving edge.

Every transfer starts with one 8-bit address byte, sent most significant bit first. Its top bit set to 1 requests a write and set to 0 requests a read. Its lower seven bits name the register. A write then takes one data byte. A read sends the addressed register back on a serial output that has a separate output enable for a tri-state pad.

The register map is small:
- Address 0 is a writable control register. Its bit 0 drives the shutdown output.
- Address 1 returns the sensor measurement input and cannot be written.
- The remaining addresses below the register count are writable scratch registers.

The control state machine has five states:
- IDLE: waits for select to rise and then moves to ADDR.
- ADDR: collects the eight address bits. It then moves to WDATA on a write and to RDATA on a read.
- WDATA: collects the eight data bits, commits the write and then moves to DONE.
- RDATA: sends the eight bits of the register and then moves to DONE.
- DONE: ignores further clock edges.

Select going low returns the machine to IDLE from any state. Each pin must stay stable for at least four system clocks between changes. Every output lags its pin cause by the synchronizer depth plus one register.

Top module: `spi_polslave`

## Requirements
- R1: After reset the output enable is 0, the shutdown output is 0, and every writable register reads 0.
- R2: The serial clock level seen when select rises sets the polarity. With polarity 1, data is captured on rising edges and driven on falling edges. With polarity 0, data is captured on falling edges and driven on rising edges.
- R3: The address byte is received most significant bit first. Bit 7 equal to 1 selects a write and 0 selects a read, and bits 6:0 select the register.
- R4: A write stores the data byte, sent most significant bit first, into the addressed register only once all 8 data bits have been captured.
- R5: A transfer that select ends before the 8th data bit leaves every register unchanged.
- R6: During a read, the output enable stays 0 throughout the address byte. It rises on the first driving edge after the address byte, and the register's bit 7 appears on that edge. The remaining bits follow in order from bit 6 down to bit 0, one per driving edge.
- R7: After bit 0 has been driven, the output keeps that level with the enable at 1 across any further clock edges. When select falls, the enable drops to 0.
- R8: While select is low, clock and data activity changes no register and the output enable stays 0.
- R9: Bit 0 of register 0 drives the shutdown output.
- R10: Reading address 1 returns the measurement input as it stood when the address byte completed. A write to address 1 has no effect.
- R11: Reading an address at or above the register count returns 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Active-high select; a transfer lasts while it is high |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data into the block |
| meas_i | input | DW | Measurement value returned at address 1 |
| miso_o | output | 1 | Serial data out of the block |
| miso_oe_o | output | 1 | Output enable for the serial data pad (1 = drive) |
| shutdown_o | output | 1 | Shutdown request, bit 0 of register 0 |

## Verification
The main function is exercised in several ways:
- Writes and reads are run in both clock polarities, and a register written in one polarity is read back in the other. This separates a correct per-transfer polarity latch from a fixed or stale one.
- Writes are cut off after 12 and after 15 bits, which exposes any commit that happens before the full byte arrives.
- Clock pulses continue past the last bit of a read, which tests the hold behaviour.
- Read-only, unmapped and idle-select patterns each confirm that nothing outside the valid write path alters state.

A behavioural pin-level model runs alongside all of this and is compared against the output, the output enable and the shutdown output on every clock.

// File: rtl/spi_polslave_pkg.sv
package spi_polslave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } ps_state_e;

    localparam int CTRL_IDX = 0;
    localparam int MEAS_IDX = 1;
    localparam int SHDN_BIT = 0;

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ps_edge_sel.sv
module ps_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_i,
    input  logic sclk_s_i,
    output logic start_o,
    output logic cap_o,
    output logic shf_o
);
    logic cs_q, sclk_q, pol_q;
    logic rise, fall, live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
            pol_q  <= 1'b0;
        end else begin
            cs_q   <= cs_s_i;
            sclk_q <= sclk_s_i;
            if (cs_s_i && !cs_q) pol_q <= sclk_s_i;
        end
    end

    assign rise    = sclk_s_i & ~sclk_q;
    assign fall    = ~sclk_s_i & sclk_q;
    assign live    = cs_s_i & cs_q;
    assign start_o = cs_s_i & ~cs_q;
    assign cap_o   = live & (pol_q ? rise : fall);
    assign shf_o   = live & (pol_q ? fall : rise);

    // R2: polarity only moves at the start of a transfer
    p_pol_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_q) |-> $stable(pol_q));

    // R2: one edge kind per clock, never both
    p_edge_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_o, shf_o}));
endmodule

// File: rtl/ps_regfile.sv
module ps_regfile
    import spi_polslave_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NUM_REGS = 4,
    parameter int AW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    input  logic [DW-1:0] meas_i,
    output logic [DW-1:0] rdata_o,
    output logic          shutdown_o
);
    logic [NUM_REGS-1:0][DW-1:0] rw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q <= '0;
        end else if (we_i) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (waddr_i == AW'(i) && i != MEAS_IDX) rw_q[i] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr_i == AW'(i)) rdata_o = (i == MEAS_IDX) ? meas_i : rw_q[i];
        end
    end

    assign shutdown_o = rw_q[CTRL_IDX][SHDN_BIT];

    // R5/R8: registers only move on a completed write
    p_rw_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(rw_q));

    // R10: measurement slot never holds written data
    p_meas_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rw_q[MEAS_IDX] == '0);
endmodule

// File: rtl/spi_polslave.sv
module spi_polslave
    import spi_polslave_pkg::*;
#(
    parameter int DW          = 8,
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          sclk_i,
    input  logic          mosi_i,
    input  logic [DW-1:0] meas_i,
    output logic          miso_o,
    output logic          miso_oe_o,
    output logic          shutdown_o
);
    localparam int AW  = DW - 1;
    localparam int BCW = $clog2(DW);

    logic          cs_s, sclk_s, mosi_s;
    logic          start, cap, shf;
    ps_state_e     state_q, state_d;
    logic [BCW-1:0] bitcnt_q;
    logic [DW-2:0] shreg_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rd_q, rdata, in_byte;
    logic          miso_q, oe_q, last_bit, we;

    ps_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_i, sclk_i, mosi_i}),
        .q_o   ({cs_s, sclk_s, mosi_s})
    );

    ps_edge_sel u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s_i   (cs_s),
        .sclk_s_i (sclk_s),
        .start_o  (start),
        .cap_o    (cap),
        .shf_o    (shf)
    );

    assign in_byte  = {shreg_q, mosi_s};
    assign last_bit = (bitcnt_q == BCW'(DW - 1));
    assign we       = (state_q == ST_WDATA) && cap && last_bit;

    ps_regfile #(.DW(DW), .NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (we),
        .waddr_i    (addr_q),
        .wdata_i    (in_byte),
        .raddr_i    (in_byte[AW-1:0]),
        .meas_i     (meas_i),
        .rdata_o    (rdata),
        .shutdown_o (shutdown_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_d = ST_ADDR;
                ST_ADDR:  if (cap && last_bit)
                              state_d = in_byte[DW-1] ? ST_WDATA : ST_RDATA;
                ST_WDATA: if (cap && last_bit) state_d = ST_DONE;
                ST_RDATA: if (shf && last_bit) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            addr_q   <= '0;
            rd_q     <= '0;
            miso_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (!cs_s) begin
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: bitcnt_q <= '0;
                ST_ADDR: if (cap) begin
                    shreg_q  <= in_byte[DW-2:0];
                    bitcnt_q <= bitcnt_q + BCW'(1);
                    if (last_bit) begin
                        addr_q   <= in_byte[AW-1:0];
                        rd_q     <= rdata;
                        bitcnt_q <= '0;
                    end
                end
                ST_WDATA: if (cap) begin
                    shreg_q  <= in_byte[DW-2:0];
                    bitcnt_q <= bitcnt_q + BCW'(1);
                end
                ST_RDATA: if (shf) begin
                    miso_q   <= rd_q[DW-1];
                    rd_q     <= {rd_q[DW-2:0], 1'b0};
                    oe_q     <= 1'b1;
                    bitcnt_q <= bitcnt_q + BCW'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign miso_o    = miso_q;
    assign miso_oe_o = oe_q;

    // R8: select low always releases the pad
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !miso_oe_o);

    // R6: pad driven only in read data or hold
    p_oe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe_o |-> (state_q == ST_RDATA || state_q == ST_DONE));

    // R6: never drive during the address byte
    p_addr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> !miso_oe_o);

    // R7: level holds once the last bit is out
    p_hold_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> $stable(miso_o));
endmodule

// File: tb/spi_polslave_tb.sv
module spi_polslave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, mosi = 1'b0;
    logic [7:0] meas = 8'h5E;
    logic miso, oe, sd;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_polslave dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .mosi_i(mosi),
        .meas_i(meas), .miso_o(miso), .miso_oe_o(oe), .shutdown_o(sd)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural pin-level reference model
    logic [7:0] mreg [4];
    int   m_ph, m_cnt;
    bit   m_pol, m_pcs, m_psclk, m_oe, m_miso;
    logic [7:0] m_sh, m_rd;
    logic [6:0] m_addr;
    bit [2:0] h_oe, h_miso, h_sd;

    function automatic logic [7:0] m_read(input logic [6:0] a);
        if (a == 7'd1) return meas;
        if (a < 7'd4) return mreg[a[1:0]];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        bit rise, fall, cap, shf;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) mreg[i] = 8'h00;
            m_ph = 0; m_cnt = 0; m_pol = 0; m_pcs = 0; m_psclk = 0;
            m_oe = 0; m_miso = 0; m_sh = 0; m_rd = 0; m_addr = 0;
            h_oe = 0; h_miso = 0; h_sd = 0;
        end else begin
            rise = sclk && !m_psclk;
            fall = !sclk && m_psclk;
            if (!sel) begin
                m_ph = 0; m_oe = 0;
            end else if (!m_pcs) begin
                m_ph = 1; m_pol = sclk; m_cnt = 0;
            end else if (m_ph != 0) begin
                cap = m_pol ? rise : fall;
                shf = m_pol ? fall : rise;
                if (m_ph == 1 && cap) begin
                    m_sh = {m_sh[6:0], mosi}; m_cnt++;
                    if (m_cnt == 8) begin
                        m_addr = m_sh[6:0]; m_cnt = 0;
                        m_rd = m_read(m_addr);
                        m_ph = m_sh[7] ? 2 : 3;
                    end
                end else if (m_ph == 2 && cap) begin
                    m_sh = {m_sh[6:0], mosi}; m_cnt++;
                    if (m_cnt == 8) begin
                        if (m_addr < 7'd4 && m_addr != 7'd1) mreg[m_addr[1:0]] = m_sh;
                        m_ph = 4;
                    end
                end else if (m_ph == 3 && shf) begin
                    m_oe = 1; m_miso = m_rd[7 - m_cnt]; m_cnt++;
                    if (m_cnt == 8) m_ph = 4;
                end
            end
            m_pcs = sel; m_psclk = sclk;
            h_oe   = {h_oe[1:0], m_oe};
            h_miso = {h_miso[1:0], m_miso};
            h_sd   = {h_sd[1:0], mreg[0][0]};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", oe, h_oe[2], "model oe");
            if (h_oe[2]) chk("R2", miso, h_miso[2], "model data");
            chk("R9", sd, h_sd[2], "model shutdown");
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input bit pol, input logic [7:0] abyte, input logic [7:0] dbyte,
                        input int nbits, input int extra, output logic [7:0] rx);
        logic [15:0] fr;
        bit is_rd;
        fr = {abyte, dbyte};
        is_rd = !abyte[7];
        rx = 8'h00;
        @(negedge clk);
        sclk = pol; idle(2*H);
        sel = 1'b1; idle(H);
        for (int i = 0; i < nbits + extra; i++) begin
            sclk = !pol;
            mosi = (i < 16) ? fr[15-i] : ~mosi;
            idle(H);
            if (i < 8) chk("R6", oe, 0, "enable during address");
            else if (is_rd && i < 16) begin
                rx[15-i] = miso;
                chk("R6", oe, 1, "enable during data");
            end else if (is_rd) begin
                chk("R7", miso, rx[0], "hold level");
                chk("R7", oe, 1, "hold enable");
            end
            sclk = pol;
            idle(H);
        end
        sel = 1'b0;
        idle(H);
        chk("R7", oe, 0, "enable after select low");
        idle(H);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rx;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        chk("R1", oe, 0, "reset enable");
        chk("R1", sd, 0, "reset shutdown");
        xfer(0, 8'h00, 8'h00, 16, 0, rx); chk("R1", rx, 8'h00, "reset reg0");
        xfer(1, 8'h02, 8'h00, 16, 0, rx); chk("R1", rx, 8'h00, "reset reg2");
        xfer(0, 8'h03, 8'h00, 16, 0, rx); chk("R1", rx, 8'h00, "reset reg3");

        // R3 R4 R9: write shutdown in polarity 0
        xfer(0, 8'h80, 8'h01, 16, 0, rx);
        chk("R9", sd, 1, "shutdown set");
        // R2 R6 R7: read back in polarity 1 with extra clocks
        xfer(1, 8'h00, 8'h00, 16, 3, rx); chk("R2", rx, 8'h01, "reg0 pol1");

        xfer(1, 8'h82, 8'hA5, 16, 0, rx);
        xfer(0, 8'h02, 8'h00, 16, 2, rx); chk("R4", rx, 8'hA5, "reg2 cross polarity");
        xfer(0, 8'h83, 8'h3C, 16, 0, rx);
        xfer(1, 8'h03, 8'h00, 16, 0, rx); chk("R3", rx, 8'h3C, "reg3 address decode");
        xfer(1, 8'h02, 8'h00, 16, 0, rx); chk("R3", rx, 8'hA5, "reg2 untouched by reg3");

        // R5: cut-short writes
        xfer(0, 8'h82, 8'hFF, 12, 0, rx);
        xfer(1, 8'h82, 8'h00, 15, 0, rx);
        xfer(0, 8'h02, 8'h00, 16, 0, rx); chk("R5", rx, 8'hA5, "truncated write");

        // R10: measurement read and write attempt
        xfer(1, 8'h01, 8'h00, 16, 0, rx); chk("R10", rx, 8'h5E, "meas read");
        xfer(0, 8'h81, 8'h00, 16, 0, rx);
        meas = 8'hC3; idle(4);
        xfer(0, 8'h01, 8'h00, 16, 0, rx); chk("R10", rx, 8'hC3, "meas after write");

        // R11: unmapped
        xfer(1, 8'h90, 8'h77, 16, 0, rx);
        xfer(1, 8'h10, 8'h00, 16, 0, rx); chk("R11", rx, 8'h00, "unmapped read");
        xfer(0, 8'h7F, 8'h00, 16, 0, rx); chk("R11", rx, 8'h00, "top address read");
        xfer(0, 8'h02, 8'h00, 16, 0, rx); chk("R11", rx, 8'hA5, "reg2 after unmapped write");

        // R8: activity with select low
        for (int i = 0; i < 20; i++) begin
            sclk = ~sclk; mosi = i[0];
            idle(H);
            chk("R8", oe, 0, "enable with select low");
        end
        chk("R8", sd, 1, "shutdown with select low");
        xfer(1, 8'h00, 8'h00, 16, 0, rx); chk("R8", rx, 8'h01, "reg0 after idle activity");

        // R9: clear shutdown
        xfer(1, 8'h80, 8'h00, 16, 0, rx);
        chk("R9", sd, 0, "shutdown cleared");
        idle(10);
        finish_run();
    end
endmodule